// File: doc/BRIEF.md
# Speculative Carry-Free Address Unit

This unit sits between register read and the data cache of a pipelined processor. For each load or store it receives a base register value and an offset. It does not wait for an adder. It ORs the low address bits of the two operands and starts the cache access with that carry-free guess at once. The true base-plus-offset sum is formed in the same cycle. The guess is judged correct exactly when base AND offset is zero over the guessed bit range, because only then does no carry move between those bits.

When the guess holds, the access finishes in the next cycle with no added delay. When it fails, the speculative result is thrown away. The unit then stalls the upstream stage for one cycle and repeats the access with the correctly added address. A store whose guess fails writes nothing in the speculative cycle. Its write happens only in the replay cycle, at the verified index. Two counters record how many accesses hit speculatively and how many had to replay.

A small behavioural data array, indexed by word and reset to zero, stands in for the cache so that the returned data can be observed.

Top module: `specAddrUnit`

## Requirements
- R1: In the cycle a request is accepted, cacheEn is 1 and cacheIndex equals bits [5:2] of (reqBase OR reqOffset). With the default widths the guessed range is the low 6 address bits: 2 byte bits and a 4-bit word index.
- R2: In the cycle a request is accepted, cacheTag equals bits [15:6] of the 16-bit wrapped sum reqBase + reqOffset.
- R3: A request is a speculative hit exactly when (reqBase AND reqOffset) is zero in bits [5:0]. A hit gives respValid = 1 one cycle after acceptance, and replayStall stays 0.
- R4: A request that misses gives replayStall = 1 for exactly the next cycle. In that cycle cacheEn is 1 and cacheIndex is taken from the true sum. respValid follows two cycles after acceptance.
- R5: A request presented while replayStall is 1 is not accepted. It has no effect and is taken only in a later cycle with replayStall = 0.
- R6: A store that misses keeps cacheWe at 0 in its request cycle and drives cacheWe = 1 in its replay cycle. A store that hits drives cacheWe = 1 in its request cycle. A load never drives cacheWe.
- R7: For a load, respData equals the word last stored at the true address's index, or 0 after reset.
- R8: hitCount increases by one for each accepted hit, and replayCount by one for each accepted miss.
- R9: After reset, replayStall, respValid, hitCount and replayCount are all 0.
- R10: A negative (two's complement) offset follows the same hit/miss rule and produces the wrapped true sum.
- R11: With respValid, respAddr holds the full true sum and respStore holds the request's store flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqBase | input | 16 | Base register value |
| reqOffset | input | 16 | Offset, may be negative |
| reqWdata | input | 32 | Store data |
| replayStall | output | 1 | Replay cycle; upstream must hold |
| cacheEn | output | 1 | Array access this cycle |
| cacheWe | output | 1 | Array write this cycle |
| cacheIndex | output | 4 | Word index driven to the array |
| cacheTag | output | 10 | Upper bits of the true address |
| respValid | output | 1 | Access completed |
| respStore | output | 1 | Completed access was a store |
| respAddr | output | 16 | True address of the completed access |
| respData | output | 32 | Load data |
| hitCount | output | 16 | Speculative hits |
| replayCount | output | 16 | Replays |

## Verification
The cache request signals (index, tag, write enable) are due in the acceptance cycle itself. The bench samples them one time step after driving the inputs on the falling edge. A hit's response is due at the next falling edge. A miss shows the stall at the next falling edge and the response at the one after. The bench's model places each expected result in a one-ahead or two-ahead slot when it accepts a request, and shifts those slots once per clock. On every falling edge it compares stall, response valid, address, store flag and load data with the slot that is due.

// File: rtl/salu_pkg.sv
package salu_pkg;
  typedef struct packed {
    logic accept;    // new request taken this cycle
    logic replay;    // replay cycle using the held true address
    logic writeNow;  // commit a store to the array this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/saluArray.sv
module saluArray #(
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               en,
  input  logic               we,
  input  logic [INDEX_W-1:0] index,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << INDEX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (en) begin
      if (we) mem[index] <= wdata;
      else    rdata <= mem[index];
    end
  end
endmodule

// File: rtl/saluDatapath.sv
module saluDatapath
  import salu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 2,
  parameter int INDEX_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic                         reqValid,
  input  logic                         reqStore,
  input  logic [ADDR_W-1:0]            reqBase,
  input  logic [ADDR_W-1:0]            reqOffset,
  input  logic [DATA_W-1:0]            reqWdata,
  output logic                         guessOk,
  output logic                         pendStore,
  output logic [INDEX_W-1:0]           cacheIndex,
  output logic [ADDR_W-BYTE_W-INDEX_W-1:0] cacheTag,
  output logic [DATA_W-1:0]            cacheWdata,
  output logic [ADDR_W-1:0]            respAddr
);
  localparam int GUESS_W = BYTE_W + INDEX_W;

  logic [GUESS_W-1:0] guessLow;
  logic [ADDR_W-1:0]  trueSum;
  logic [ADDR_W-1:0]  pendSum;
  logic [DATA_W-1:0]  pendWdata;

  // carry-free guess: one OR level before the array index
  assign guessLow = reqBase[GUESS_W-1:0] | reqOffset[GUESS_W-1:0];
  // true sum, off the array path
  assign trueSum  = reqBase + reqOffset;
  // no carry inside the guessed range <=> no overlapping ones
  assign guessOk  = ~|(reqBase[GUESS_W-1:0] & reqOffset[GUESS_W-1:0]);

  always_comb begin
    if (strobe.replay) begin
      cacheIndex = pendSum[GUESS_W-1:BYTE_W];
      cacheTag   = pendSum[ADDR_W-1:GUESS_W];
      cacheWdata = pendWdata;
    end else begin
      cacheIndex = guessLow[GUESS_W-1:BYTE_W];
      cacheTag   = trueSum[ADDR_W-1:GUESS_W];
      cacheWdata = reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSum   <= '0;
      pendWdata <= '0;
      pendStore <= 1'b0;
      respAddr  <= '0;
    end else begin
      if (strobe.accept) begin
        pendSum   <= trueSum;
        pendWdata <= reqWdata;
        pendStore <= reqStore;
        respAddr  <= trueSum;
      end else if (strobe.replay) begin
        respAddr  <= pendSum;
      end
    end
  end

  // R3: the AND test and a comparison against the adder output agree
  guess_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (guessOk == (guessLow == trueSum[GUESS_W-1:0])));
endmodule

// File: rtl/saluControl.sv
module saluControl
  import salu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic             guessOk,
  input  logic             pendStore,
  output ctrlStrobe_t      strobe,
  output logic             replayStall,
  output logic             cacheEn,
  output logic             respValid,
  output logic             respStore,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] replayCount
);
  logic replayPend;

  assign replayStall     = replayPend;
  assign strobe.replay   = replayPend;
  assign strobe.accept   = reqValid & ~replayPend;
  assign strobe.writeNow = (strobe.accept & reqStore & guessOk) |
                           (replayPend & pendStore);
  assign cacheEn         = strobe.accept | replayPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      replayPend  <= 1'b0;
      respValid   <= 1'b0;
      respStore   <= 1'b0;
      hitCount    <= '0;
      replayCount <= '0;
    end else begin
      replayPend <= strobe.accept & ~guessOk;
      respValid  <= (strobe.accept & guessOk) | replayPend;
      respStore  <= replayPend ? pendStore : reqStore;
      if (strobe.accept & guessOk)  hitCount    <= hitCount + 1'b1;
      if (strobe.accept & ~guessOk) replayCount <= replayCount + 1'b1;
    end
  end

  // R4
  single_replay_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayStall |=> !replayStall);
  // R4
  replay_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayStall |=> respValid);
  // R5
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayStall |-> !strobe.accept);
  // R6
  no_spec_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !replayStall && !guessOk) |-> !strobe.writeNow);
  // R8
  hit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && guessOk) |=> (hitCount == $past(hitCount) + 1'b1));
endmodule

// File: rtl/specAddrUnit.sv
module specAddrUnit
  import salu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 2,
  parameter int INDEX_W = 4,
  parameter int CNT_W   = 16,
  localparam int TAG_W  = ADDR_W - BYTE_W - INDEX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqStore,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [ADDR_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               replayStall,
  output logic               cacheEn,
  output logic               cacheWe,
  output logic [INDEX_W-1:0] cacheIndex,
  output logic [TAG_W-1:0]   cacheTag,
  output logic               respValid,
  output logic               respStore,
  output logic [ADDR_W-1:0]  respAddr,
  output logic [DATA_W-1:0]  respData,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   replayCount
);
  ctrlStrobe_t       strobe;
  logic              guessOk;
  logic              pendStore;
  logic [DATA_W-1:0] cacheWdata;

  assign cacheWe = strobe.writeNow;

  saluControl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .guessOk(guessOk), .pendStore(pendStore), .strobe(strobe),
    .replayStall(replayStall), .cacheEn(cacheEn), .respValid(respValid),
    .respStore(respStore), .hitCount(hitCount), .replayCount(replayCount)
  );

  saluDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
                 .INDEX_W(INDEX_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(reqValid),
    .reqStore(reqStore), .reqBase(reqBase), .reqOffset(reqOffset),
    .reqWdata(reqWdata), .guessOk(guessOk), .pendStore(pendStore),
    .cacheIndex(cacheIndex), .cacheTag(cacheTag), .cacheWdata(cacheWdata),
    .respAddr(respAddr)
  );

  saluArray #(.DATA_W(DATA_W), .INDEX_W(INDEX_W)) uArray (
    .clk(clk), .rstN(rstN), .en(cacheEn), .we(strobe.writeNow),
    .index(cacheIndex), .wdata(cacheWdata), .rdata(respData)
  );
endmodule

// File: tb/tb_specAddrUnit.sv
module tb_specAddrUnit;
  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, reqStore = 0;
  logic [15:0] reqBase = 0, reqOffset = 0;
  logic [31:0] reqWdata = 0;
  logic replayStall, cacheEn, cacheWe, respValid, respStore;
  logic [3:0] cacheIndex;
  logic [9:0] cacheTag;
  logic [15:0] respAddr, hitCount, replayCount;
  logic [31:0] respData;

  always #10 clk = ~clk;

  specAddrUnit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqWdata(reqWdata),
    .replayStall(replayStall), .cacheEn(cacheEn), .cacheWe(cacheWe),
    .cacheIndex(cacheIndex), .cacheTag(cacheTag), .respValid(respValid),
    .respStore(respStore), .respAddr(respAddr), .respData(respData),
    .hitCount(hitCount), .replayCount(replayCount)
  );

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  // model state
  logic [31:0] mem [16];
  int hits = 0, replays = 0;
  bit nxtV = 0, aftV = 0, nxtStall = 0, pStore = 0;
  bit nxtSt = 0, aftSt = 0;
  logic [15:0] nxtA = 0, aftA = 0, pSum = 0;
  logic [31:0] nxtD = 0, aftD = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: compare due slot, then optionally present a request
  task automatic step(input bit v, input bit st, input logic [15:0] b,
                      input logic [15:0] o, input logic [31:0] wd,
                      output bit taken);
    bit curV, curSt, curStall, hit;
    logic [15:0] curA, sum;
    logic [31:0] curD;
    @(negedge clk);
    curV = nxtV; curSt = nxtSt; curA = nxtA; curD = nxtD; curStall = nxtStall;
    nxtV = aftV; nxtSt = aftSt; nxtA = aftA; nxtD = aftD;
    aftV = 0; nxtStall = 0;
    chk(replayStall == curStall, "R4 stall", 32'(replayStall), 32'(curStall));
    chk(respValid == curV, "R3 respValid", 32'(respValid), 32'(curV));
    if (curV && respValid) begin
      chk(respAddr == curA, "R11 respAddr", 32'(respAddr), 32'(curA));
      chk(respStore == curSt, "R11 respStore", 32'(respStore), 32'(curSt));
      if (!curSt) chk(respData == curD, "R7 load data", respData, curD);
    end
    reqValid = v; reqStore = st; reqBase = b; reqOffset = o; reqWdata = wd;
    #1;
    taken = 0;
    if (curStall) begin
      chk(cacheEn && cacheIndex == pSum[5:2], "R4 replay index",
          32'(cacheIndex), 32'(pSum[5:2]));
      chk(cacheWe == pStore, "R6 replay write", 32'(cacheWe), 32'(pStore));
    end else if (v) begin
      sum = b + o;
      hit = ((b & o) & 16'h003F) == 0;
      chk(cacheEn && cacheIndex == ((b | o) >> 2) % 16, "R1 guess index",
          32'(cacheIndex), 32'(((b | o) >> 2) % 16));
      chk(cacheTag == sum[15:6], "R2 tag", 32'(cacheTag), 32'(sum[15:6]));
      chk(cacheWe == (st && hit), "R6 spec write", 32'(cacheWe), 32'(st && hit));
      taken = 1;
      if (hit) begin
        hits++;
        nxtV = 1; nxtSt = st; nxtA = sum; nxtD = mem[sum[5:2]];
      end else begin
        replays++;
        nxtStall = 1; pSum = sum; pStore = st;
        aftV = 1; aftSt = st; aftA = sum; aftD = mem[sum[5:2]];
      end
      if (st) mem[sum[5:2]] = wd;
    end else begin
      chk(!cacheWe, "R6 idle write", 32'(cacheWe), 0);
    end
  endtask

  task automatic issue(input bit st, input logic [15:0] b, input logic [15:0] o,
                       input logic [31:0] wd);
    bit taken;
    int tries = 0;
    taken = 0;
    while (!taken) begin
      step(1, st, b, o, wd, taken);
      tries++;
      // R5: a request seen during a stall must wait
      if (tries > 1) chk(1'b1, "R5", 0, 0);
    end
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, t);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9
    chk(replayStall == 0 && respValid == 0, "R9 reset outputs",
        32'({replayStall, respValid}), 0);
    chk(hitCount == 0 && replayCount == 0, "R9 reset counters",
        32'(hitCount + replayCount), 0);
    // R7 load of reset contents, hit
    issue(0, 16'h1000, 16'h0004, 0);
    idle(2);
    // R3 hit store then R4 miss store (0x0003+0x0001 = 4, index 1)
    issue(1, 16'h2000, 16'h0008, 32'hAAAA0001);
    issue(1, 16'h0003, 16'h0001, 32'hBBBB0002);
    // R5 load presented during the stall cycle, must read new data
    issue(0, 16'h0004, 16'h0000, 0);
    issue(0, 16'h2000, 16'h0008, 0);
    // R10 negative offsets: miss and hit
    issue(0, 16'h0010, 16'hFFFC, 0);
    issue(1, 16'h0040, 16'hFFF0, 32'hCCCC0003);
    issue(0, 16'h0030, 16'h0000, 0);
    idle(3);
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [15:0] b, o;
      b = 16'($urandom);
      o = (n % 3 == 0) ? 16'($urandom_range(0, 63)) : 16'($urandom);
      if (n % 7 == 0) o = -o;
      if (n % 11 == 0) idle(1);
      issue(($urandom % 2) == 1, b, o, $urandom);
    end
    idle(4);
    // R8
    chk(hitCount == 16'(hits), "R8 hitCount", 32'(hitCount), hits);
    chk(replayCount == 16'(replays), "R8 replayCount", 32'(replayCount), replays);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule